// File: doc/BRIEF.md
# BCD Watchdog Timer with Interrupt/Reset Steering

The block is a watchdog timer for a host processor. The host programs a timeout as four BCD digits, which gives 00.01 s to 99.99 s in 10 ms steps. The block counts that value down, one step per strobe on a 100 Hz tick input. Every expiry reloads the count and sets a sticky timeout flag. This happens even while the watchdog is disabled, so software can poll the flag.

With the enable bit set, a steering bit chooses what an expiry does:

- **Repeating interrupt mode:** the expiry raises an interrupt flag and pulls the active-low interrupt pin.
- **One-shot reset mode:** the expiry drives an active-low reset pulse of fixed length. The enable bit then clears itself when the pulse ends.

The host reaches the block through a small register port:

| Address | Register | Access |
|---|---|---|
| 0 | Status | Read only. A read clears the flags. |
| 1 | Control | Read/write |
| 2 | Low timeout byte | Read/write |
| 3 | High timeout byte | Read/write |

Generating the tick from a crystal and producing the power-on reset are left to neighbouring logic.

Top module: `wdg_bcd_steer`

## Requirements
- R1: After reset the enable and steering bits and both flags are 0. The status and control registers read 00h, and both `irq_n` and `wdt_rst_n` are high.
- R2: The timeout byte at address 2 holds tenths of a second in bits 7:4 and hundredths in bits 3:0. The byte at address 3 holds tens of seconds in bits 7:4 and units in bits 3:0. After a load of decimal value N, the N-th tick is the expiry. The count steps down with BCD borrow across all four digits, from 00.01 up to 99.99.
- R3: A write to either timeout byte reloads the count from the written value and restarts the period. The write wins over a tick in the same cycle, and that tick does not expire.
- R4: An expiry reloads the count from the timeout bytes, so expiries repeat every N ticks.
- R5: Every expiry sets the timeout flag (status bit 0), whatever the enable and steering bits hold.
- R6: With enable=1 and steering=0, an expiry sets the interrupt flag (status bit 1), and `irq_n` is low from the next cycle. `irq_n` is always the inverse of the interrupt flag.
- R7: A read of the status register returns the flags and clears both of them at the clock edge, so `irq_n` goes high. If an expiry falls in the same cycle, the flags stay set.
- R8: With enable=1 and steering=1, an expiry drives `wdt_rst_n` low from the next cycle for exactly RST_TICKS ticks. It leaves the interrupt flag alone. The enable bit clears at the tick that ends the pulse, and the steering bit is kept. Expiries during a pulse do not retrigger it. A control write in the cycle the pulse ends takes priority over that clear.
- R9: While both timeout bytes are 00h, no expiry occurs for any number of ticks.
- R10: The control register holds enable in bit 1 and steering in bit 0. Its other bits read 0. Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at 100 Hz, one countdown step |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read clears the flags) |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low interrupt |
| wdt_rst_n | output | 1 | Active-low watchdog reset pulse |

## Verification
The bench builds the block with DIGITS=4, DATA_W=8 and ADDR_W=2, so the full four-digit BCD range is in play. This includes a 99.99 load whose borrow ripples through every digit over 9999 ticks. It shortens RST_TICKS to 4, so that several expiries fall inside one reset pulse and the no-retrigger rule and the self-clearing enable are reached within a short run. Ticks are fed on every cycle for the long loads and sparsely elsewhere. This lines a status read, a reload write and a control write up against an expiry or against the end of a pulse in the same cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    WM_OFF     = 2'd0,
    WM_REPEAT  = 2'd1,
    WM_ONESHOT = 2'd2
  } wdg_mode_t;

  typedef struct packed {
    logic       borrow;
    logic [3:0] digit;
  } bcd_step_t;

  // One BCD digit of a decrement: takes a borrow in, gives digit and borrow out.
  function automatic bcd_step_t bcd_digit_dec(input logic [3:0] d, input logic bin);
    bcd_step_t r;
    if (!bin) begin
      r.borrow = 1'b0;
      r.digit  = d;
    end else if (d == 4'd0) begin
      r.borrow = 1'b1;
      r.digit  = 4'd9;
    end else begin
      r.borrow = 1'b0;
      r.digit  = d - 4'd1;
    end
    return r;
  endfunction

  function automatic wdg_mode_t wdg_mode(input logic en, input logic steer);
    if (!en)   return WM_OFF;
    if (steer) return WM_ONESHOT;
    return WM_REPEAT;
  endfunction

endpackage

// File: rtl/wdg_bcd_countdown.sv
module wdg_bcd_countdown
  import wdg_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                load,
  input  logic [DIGITS*4-1:0] load_val,
  input  logic [DIGITS*4-1:0] reload_val,
  output logic                timeout_evt,
  output logic                reload_zero
);
  localparam int CW = DIGITS * 4;

  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_dec;
  logic [DIGITS:0] borrow;
  logic            cnt_zero;
  logic            cnt_one;

  assign borrow[0] = 1'b1;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
      bcd_step_t s;
      assign s                = bcd_digit_dec(cnt_q[i*4 +: 4], borrow[i]);
      assign cnt_dec[i*4 +: 4] = s.digit;
      assign borrow[i+1]      = s.borrow;
    end
  endgenerate

  // A borrow out of the top digit means the count was all zero.
  assign cnt_zero    = borrow[DIGITS];
  assign cnt_one     = (cnt_q == CW'(1));
  assign reload_zero = (reload_val == '0);
  assign timeout_evt = tick && !load && !reload_zero && cnt_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && !reload_zero) begin
      if (cnt_zero || cnt_one) cnt_q <= reload_val;
      else                     cnt_q <= cnt_dec;
    end
  end

endmodule

// File: rtl/wdg_rst_pulse.sv
module wdg_rst_pulse #(
  parameter int PULSE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic active,
  output logic done
);
  localparam int PW = $clog2(PULSE_TICKS + 1);

  logic [PW-1:0] left_q;

  assign active = (left_q != '0);
  assign done   = tick && (left_q == PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (start && !active) begin
      left_q <= PW'(PULSE_TICKS);
    end else if (tick && active) begin
      left_q <= left_q - PW'(1);
    end
  end

endmodule

// File: rtl/wdg_regs.sv
module wdg_regs #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 8,
  parameter int TO_BYTES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         set_wdf,
  input  logic                         set_irq,
  input  logic                         clr_en,
  output logic [DATA_W-1:0]            rdata,
  output logic                         en,
  output logic                         steer,
  output logic                         wdf,
  output logic                         irqf,
  output logic                         to_load,
  output logic [TO_BYTES*DATA_W-1:0]   to_next,
  output logic [TO_BYTES*DATA_W-1:0]   to_cur
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(1);
  localparam int                A_TO0    = 2;

  logic [TO_BYTES-1:0] to_hit;
  logic                status_rd;
  logic                ctrl_wr;

  assign status_rd = rd_en && (addr == A_STATUS);
  assign ctrl_wr   = wr_en && (addr == A_CTRL);

  generate
    for (genvar b = 0; b < TO_BYTES; b++) begin : g_to_byte
      assign to_hit[b] = wr_en && (addr == ADDR_W'(A_TO0 + b));
      assign to_next[b*DATA_W +: DATA_W] = to_hit[b] ? wdata : to_cur[b*DATA_W +: DATA_W];
    end
  endgenerate

  assign to_load = |to_hit;

  // Timeout bytes are deliberately left without reset.
  always_ff @(posedge clk) begin
    to_cur <= to_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      steer <= 1'b0;
      wdf   <= 1'b0;
      irqf  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        en    <= wdata[1];
        steer <= wdata[0];
      end else if (clr_en) begin
        en <= 1'b0;
      end
      if (set_wdf)        wdf <= 1'b1;
      else if (status_rd) wdf <= 1'b0;
      if (set_irq)        irqf <= 1'b1;
      else if (status_rd) irqf <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_STATUS) begin
      rdata[0] = wdf;
      rdata[1] = irqf;
    end else if (addr == A_CTRL) begin
      rdata[0] = steer;
      rdata[1] = en;
    end else begin
      for (int b = 0; b < TO_BYTES; b++) begin
        if (addr == ADDR_W'(A_TO0 + b)) rdata = to_cur[b*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/wdg_bcd_steer.sv
module wdg_bcd_steer
  import wdg_pkg::*;
#(
  parameter int DIGITS    = 4,
  parameter int RST_TICKS = 10,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n,
  output logic              wdt_rst_n
);
  localparam int CW       = DIGITS * 4;
  localparam int TO_BYTES = CW / DATA_W;

  // Internal events, named so the checker can watch them.
  logic          timeout_evt;
  logic          reload_zero;
  logic          irq_set;
  logic          pulse_start;
  logic          pulse_done;
  logic          pulse_active;
  logic          en;
  logic          steer;
  logic          wdf;
  logic          irqf;
  logic          to_load;
  logic [CW-1:0] to_next;
  logic [CW-1:0] to_cur;
  wdg_mode_t     mode;

  assign mode        = wdg_mode(en, steer);
  assign irq_set     = timeout_evt && (mode == WM_REPEAT);
  assign pulse_start = timeout_evt && (mode == WM_ONESHOT);

  wdg_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TO_BYTES (TO_BYTES)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .set_wdf (timeout_evt),
    .set_irq (irq_set),
    .clr_en  (pulse_done),
    .rdata   (rdata),
    .en      (en),
    .steer   (steer),
    .wdf     (wdf),
    .irqf    (irqf),
    .to_load (to_load),
    .to_next (to_next),
    .to_cur  (to_cur)
  );

  wdg_bcd_countdown #(
    .DIGITS (DIGITS)
  ) u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .load        (to_load),
    .load_val    (to_next),
    .reload_val  (to_cur),
    .timeout_evt (timeout_evt),
    .reload_zero (reload_zero)
  );

  wdg_rst_pulse #(
    .PULSE_TICKS (RST_TICKS)
  ) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .start  (pulse_start),
    .active (pulse_active),
    .done   (pulse_done)
  );

  assign irq_n     = ~irqf;
  assign wdt_rst_n = ~pulse_active;

endmodule

// File: rtl/wdg_bcd_steer_chk.sv
module wdg_bcd_steer_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              irq_n,
  input logic              wdt_rst_n,
  input logic              timeout_evt,
  input logic              reload_zero,
  input logic              en,
  input logic              steer,
  input logic              wdf
);

  a_r5_timeout_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> wdf);

  a_r6_repeat_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && en && !steer) |=> !irq_n);

  a_r7_read_releases_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(0) && !timeout_evt) |=> irq_n);

  a_r8_pulse_from_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_n) |-> $past(timeout_evt && en && steer));

  a_r8_enable_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wdt_rst_n) && !$past(wr_en && addr == ADDR_W'(1))) |-> !en);

  a_r8_oneshot_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && en && steer && irq_n && !(rd_en && addr == ADDR_W'(0))) |=> irq_n);

  a_r9_zero_never_expires: assert property (@(posedge clk) disable iff (!rst_n)
    reload_zero |-> !timeout_evt);

endmodule

bind wdg_bcd_steer wdg_bcd_steer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_en       (rd_en),
  .wr_en       (wr_en),
  .addr        (addr),
  .irq_n       (irq_n),
  .wdt_rst_n   (wdt_rst_n),
  .timeout_evt (timeout_evt),
  .reload_zero (reload_zero),
  .en          (en),
  .steer       (steer),
  .wdf         (wdf)
);

// File: tb/tb_wdg_bcd_steer.sv
`timescale 1ns/1ps
module tb_wdg_bcd_steer;
  localparam int RT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_n;
  logic       wdt_rst_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // Reference model state
  int   m_cnt = 0;
  int   m_pulse = 0;
  bit   m_en = 0, m_steer = 0, m_wdf = 0, m_irqf = 0;
  logic [7:0] m_lo = 8'h00, m_hi = 8'h00;

  wdg_bcd_steer #(.DIGITS(4), .RST_TICKS(RT), .ADDR_W(2), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .wdt_rst_n(wdt_rst_n)
  );

  always #5 clk = ~clk;

  function automatic int bcd_val(input logic [7:0] lo, input logic [7:0] hi);
    return int'(hi[7:4]) * 1000 + int'(hi[3:0]) * 100 + int'(lo[7:4]) * 10 + int'(lo[3:0]);
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0:    return {6'b0, m_irqf, m_wdf};
      2'd1:    return {6'b0, m_en, m_steer};
      2'd2:    return m_lo;
      default: return m_hi;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic model_edge(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d, input bit t);
    int  old_reload;
    bit  load, toev, done, start;
    old_reload = bcd_val(m_lo, m_hi);
    load  = w && (a >= 2);
    toev  = t && !load && old_reload != 0 && m_cnt == 1;
    done  = t && m_pulse == 1;
    start = toev && m_en && m_steer && m_pulse == 0;
    if (start) m_pulse = RT;
    else if (t && m_pulse > 0) m_pulse--;
    if (toev) m_wdf = 1; else if (r && a == 0) m_wdf = 0;
    if (toev && m_en && !m_steer) m_irqf = 1; else if (r && a == 0) m_irqf = 0;
    if (w && a == 1) begin m_en = d[1]; m_steer = d[0]; end
    else if (done) m_en = 0;
    if (w && a == 2) m_lo = d;
    if (w && a == 3) m_hi = d;
    if (load) m_cnt = bcd_val(m_lo, m_hi);
    else if (t && old_reload != 0) begin
      if (m_cnt <= 1) m_cnt = old_reload; else m_cnt--;
    end
  endtask

  // One clock: drive after negedge, check read data, clock, then compare pins.
  task automatic step(input bit w, input bit r, input logic [1:0] a, input logic [7:0] d,
                      input bit t, input string req);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
    #1;
    if (r) check(rdata == m_read(a), req, "rdata", int'(rdata), int'(m_read(a)));
    @(posedge clk);
    model_edge(w, r, a, d, t);
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick = 0;
    check(irq_n == !m_irqf, "R6", "irq_n", int'(irq_n), int'(!m_irqf));
    check(wdt_rst_n == (m_pulse == 0), "R8", "wdt_rst_n", int'(wdt_rst_n), int'(m_pulse == 0));
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1, 0, a, d, 0, "R10");
  endtask

  task automatic rd(input logic [1:0] a, input string req);
    step(0, 1, a, 8'h00, 0, req);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 2'd0, 8'h00, 1, "R4");
      for (int g = 0; g < gap; g++) step(0, 0, 2'd0, 8'h00, 0, "R4");
    end
  endtask

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual %0d expected <150000 cycles", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(irq_n == 1'b1, "R1", "irq_n after reset", int'(irq_n), 1);
    check(wdt_rst_n == 1'b1, "R1", "wdt_rst_n after reset", int'(wdt_rst_n), 1);
    rd(2'd0, "R1");
    rd(2'd1, "R1");

    // R5: disabled watchdog still sets the timeout flag, no interrupt
    wr(2'd2, 8'h05); wr(2'd3, 8'h00);
    rd(2'd2, "R2"); rd(2'd3, "R2");
    ticks(4, 1);
    rd(2'd0, "R5");            // not yet expired
    ticks(1, 1);
    rd(2'd0, "R5");            // expired, flag read and cleared
    rd(2'd0, "R7");            // cleared
    ticks(10, 1);              // R4: two more expiries
    rd(2'd0, "R4");

    // R10: status writes ignored, control unused bits read 0
    ticks(5, 0);
    wr(2'd0, 8'hFF);
    rd(2'd0, "R10");
    wr(2'd1, 8'hFC);
    rd(2'd1, "R10");

    // R6: repeating interrupt mode
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h03);
    ticks(3, 1);
    check(irq_n == 1'b0, "R6", "irq_n low after expiry", int'(irq_n), 0);
    rd(2'd0, "R6");
    check(irq_n == 1'b1, "R7", "irq_n released by status read", int'(irq_n), 1);

    // R3: reload write restarts the period, write beats tick in the same cycle
    ticks(2, 0);
    step(1, 0, 2'd2, 8'h03, 1, "R3");
    ticks(2, 0);
    rd(2'd0, "R3");            // must still read 00
    ticks(1, 0);
    rd(2'd0, "R3");            // now 03

    // R7: status read in the expiry cycle keeps the flags
    wr(2'd2, 8'h01);
    step(0, 1, 2'd0, 8'h00, 1, "R7");
    rd(2'd0, "R7");
    check(irq_n == 1'b1, "R7", "irq_n after second read", int'(irq_n), 1);

    // R2: BCD borrow across digits, 01.00 and 10.00
    wr(2'd2, 8'h00); wr(2'd3, 8'h01);
    rd(2'd0, "R2");
    ticks(99, 0);
    rd(2'd0, "R2");
    ticks(1, 0);
    rd(2'd0, "R2");
    wr(2'd3, 8'h10);
    ticks(1000, 0);
    rd(2'd0, "R2");

    // R9: zero timeout never expires
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    ticks(300, 0);
    rd(2'd0, "R9");

    // R8: one-shot reset pulse, no retrigger, enable clears, irq untouched
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h02);
    ticks(2, 1);
    check(wdt_rst_n == 1'b0, "R8", "pulse started", int'(wdt_rst_n), 0);
    ticks(RT, 1);
    check(wdt_rst_n == 1'b1, "R8", "pulse ended", int'(wdt_rst_n), 1);
    rd(2'd1, "R8");
    rd(2'd0, "R8");
    ticks(6, 0);               // disabled now: only the flag sets
    check(wdt_rst_n == 1'b1, "R8", "no pulse once disabled", int'(wdt_rst_n), 1);

    // R8: control write at the pulse's last tick wins over the clear
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h02);
    ticks(2, 0);
    ticks(RT - 1, 0);
    step(1, 0, 2'd1, 8'h03, 1, "R8");
    rd(2'd1, "R8");
    wr(2'd1, 8'h00);

    // R2: full-scale 99.99
    wr(2'd2, 8'h99); wr(2'd3, 8'h99);
    rd(2'd0, "R2");
    ticks(9998, 0);
    rd(2'd0, "R2");
    ticks(1, 0);
    rd(2'd0, "R2");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule